// File: doc/BRIEF.md
# Device-to-Host Virtual Wire Transmit Group

This block keeps four device-driven virtual wire bits that share one 8-bit wire index. Firmware sets the index, a reset-control byte and the individual wire states through a small byte-addressed register port. Each write to a wire's state byte records that wire as changed. The change flag is set even when the written value equals the value the wire already holds.

While any change flag is set, the block asks the link for a transfer through a valid/ready handshake. The request carries the index and all four wire states together, including wires that did not change. When the handshake completes, the flags that were pending are cleared. A write that arrives in the same cycle as the completion keeps its own flag, so that new value is still sent in a later transfer.

The reset-control byte selects one of four reset domains and holds a default pattern for the wires. A reset event on the selected domain loads that pattern and drops every pending flag.

Top module: `vw_uplink_group`

## Requirements
- R1: After the power-on reset `rst_n`, every readable byte reads 0 and `tx_valid` is low.
- R2: A write to byte 0 sets the index, which reads back at byte 0 and drives `tx_index`. A write to byte 1 stores the domain select in bits [1:0] and the wire defaults in bits [7:4]. Bits [3:2] of byte 1 read 0.
- R3: A write to byte 4+k (k = 0..3) sets wire k to `wr_data[0]` and sets change flag k. The other wires do not change. Byte 4+k reads `{7'b0, wire k}`.
- R4: A write that gives a wire the value it already holds still sets that wire's change flag.
- R5: Byte 2 reads the change flags in bits [3:0], with flag k in bit k and bits [7:4] at 0. Writes to byte 2 and byte 3 have no effect.
- R6: `tx_valid` is high exactly when at least one change flag is set. `tx_wires` carries all four wire states, with wire 0 in bit 0.
- R7: A cycle with `tx_valid` and `tx_ready` both high clears every flag that was set. While `tx_ready` is low, the request and its payload stay the same unless a write or a reset event occurs.
- R8: A wire write in the same cycle as a completed handshake leaves that wire's flag set after the cycle.
- R9: A pulse on `dom_rst[s]`, where s is the domain select, loads the wire defaults into the wires and clears all flags. Pulses on the other domains have no effect.
- R10: When a reset event on the selected domain and a wire write fall in the same cycle, the reset event wins. A byte 1 write in that same cycle takes effect only in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| dom_rst | input | 4 | Reset event pulse for each of the four domains |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 3 | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Byte address of the read |
| rd_data | output | 8 | Read data byte (combinational) |
| tx_valid | output | 1 | Transfer request to the link |
| tx_ready | input | 1 | Link accepts the transfer |
| tx_index | output | 8 | Wire index of the transfer |
| tx_wires | output | 4 | All four wire states, wire 0 in bit 0 |

## Verification
The directed steps first write single wires one at a time, so a wrong bit lane or a write that disturbs its neighbours shows up. They then write a wire with the value it already holds, which catches change detection done by value comparison instead of by write. A completion is placed in the same cycle as a new write, which separates clearing all flags from clearing only the flags that were sent. Reset events are pulsed on both the unselected and the selected domains, and also together with a wire write, to show which domain is honoured and which action wins. A long pseudo-random phase then mixes writes, ready pulses, reset events and reads, compared against the model on every cycle.

// File: rtl/vw_uplink_group.sv
module vw_uplink_group (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dom_rst,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_index,
  output logic [3:0] tx_wires
);
  localparam int NW = 4;

  logic [7:0]    idx_q;
  logic [1:0]    dom_q;
  logic [NW-1:0] dflt_q;
  logic [NW-1:0] wire_q;
  logic [NW-1:0] flag_q;

  wire           dom_hit = dom_rst[dom_q];
  wire           fire    = tx_valid & tx_ready;
  wire           st_wr   = wr_en & wr_addr[2];
  wire [NW-1:0]  wr_sel  = st_wr ? (NW'(1) << wr_addr[1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dom_q  <= '0;
      dflt_q <= '0;
      wire_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && wr_addr == 3'd0) idx_q <= wr_data;
      if (wr_en && wr_addr == 3'd1) begin
        dom_q  <= wr_data[1:0];
        dflt_q <= wr_data[7:4];
      end
      if (dom_hit) begin
        wire_q <= dflt_q;
        flag_q <= '0;
      end else begin
        wire_q <= (wire_q & ~wr_sel) | (wr_sel & {NW{wr_data[0]}});
        flag_q <= (fire ? '0 : flag_q) | wr_sel;
      end
    end
  end

  assign tx_valid = |flag_q;
  assign tx_index = idx_q;
  assign tx_wires = wire_q;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = idx_q;
      3'd1:    rd_data = {dflt_q, 2'b00, dom_q};
      3'd2:    rd_data = {4'b0000, flag_q};
      3'd4, 3'd5, 3'd6, 3'd7:
               rd_data = {7'b0, wire_q[rd_addr[1:0]]};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module vw_uplink_group_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] dom_rst,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_index,
  input logic [3:0] tx_wires,
  input logic [1:0] dom_q,
  input logic [3:0] dflt_q
);
  wire sel_evt = dom_rst[dom_q];
  wire wire_wr = wr_en & wr_addr[2];

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !wr_en && !(|dom_rst)
    |=> tx_valid && $stable(tx_wires) && $stable(tx_index));

  assert_domain_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_evt |=> !tx_valid && tx_wires == $past(dflt_q));

  assert_write_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wire_wr && !sel_evt |=> tx_valid);

  assert_keep_late_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && wire_wr && !sel_evt |=> tx_valid);

  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !wire_wr |=> !tx_valid);
endmodule

bind vw_uplink_group vw_uplink_group_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dom_rst(dom_rst), .wr_en(wr_en),
  .wr_addr(wr_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_index(tx_index), .tx_wires(tx_wires), .dom_q(dom_q), .dflt_q(dflt_q)
);

// File: tb/vw_uplink_group_test.sv
module vw_uplink_group_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dom_rst = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic       tx_ready = 1'b0;
  logic [7:0] rd_data;
  logic       tx_valid;
  logic [7:0] tx_index;
  logic [3:0] tx_wires;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // behavioural model
  int m_idx, m_dom, m_dflt;
  bit m_wire [4];
  bit m_flag [4];

  always #10 clk = ~clk;

  vw_uplink_group uut (
    .clk(clk), .rst_n(rst_n), .dom_rst(dom_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_index(tx_index), .tx_wires(tx_wires)
  );

  function automatic bit any_flag();
    bit r = 0;
    for (int k = 0; k < 4; k++) r |= m_flag[k];
    return r;
  endfunction

  function automatic int exp_read(int a);
    int f = 0;
    case (a)
      0: return m_idx;
      1: return (m_dflt << 4) | m_dom;
      2: begin
           for (int k = 0; k < 4; k++) if (m_flag[k]) f += (1 << k);
           return f;
         end
      4, 5, 6, 7: return int'(m_wire[a - 4]);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_wires();
    int w = 0;
    for (int k = 0; k < 4; k++) if (m_wire[k]) w += (1 << k);
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_dom = 0; m_dflt = 0;
      for (int k = 0; k < 4; k++) begin m_wire[k] = 0; m_flag[k] = 0; end
    end else begin
      automatic bit sent = any_flag() && tx_ready;
      automatic bit hit = dom_rst[m_dom];
      automatic int old_dflt = m_dflt;
      if (wr_en && wr_addr == 0) m_idx = wr_data;
      if (wr_en && wr_addr == 1) begin m_dom = wr_data & 3; m_dflt = wr_data >> 4; end
      if (hit) begin
        for (int k = 0; k < 4; k++) begin
          m_wire[k] = old_dflt[k];
          m_flag[k] = 0;
        end
      end else begin
        if (sent) for (int k = 0; k < 4; k++) m_flag[k] = 0;
        if (wr_en && wr_addr >= 4) begin
          m_wire[wr_addr - 4] = wr_data[0];
          m_flag[wr_addr - 4] = 1;
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs applied now, outputs compared after the edge
  task automatic step(bit we, int wa, int wd, bit rdy, int evt, int ra);
    wr_en = we; wr_addr = 3'(wa); wr_data = 8'(wd);
    tx_ready = rdy; dom_rst = 4'(evt); rd_addr = 3'(ra);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; tx_ready = 0; dom_rst = 0;
    chk("tx_valid", int'(tx_valid), int'(any_flag()));
    chk("tx_index", int'(tx_index), m_idx);
    chk("tx_wires", int'(tx_wires), exp_wires());
    chk("rd_data", int'(rd_data), exp_read(ra));
  endtask

  initial begin
    int lfsr = 32'h1ACE5;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("tx_valid", int'(tx_valid), 0);
    rst_n = 1;
    for (int a = 0; a < 8; a++) step(0, 0, 0, 0, 0, a);
    tag = "R2";
    step(1, 0, 8'hA5, 0, 0, 0);
    step(1, 1, 8'hFF, 0, 0, 1);          // bits [3:2] read 0 -> F3
    step(1, 1, 8'h00, 0, 0, 1);
    tag = "R3";
    step(1, 5, 1, 0, 0, 5);              // wire1 only
    step(0, 0, 0, 0, 0, 4);
    tag = "R4";
    step(1, 4, 0, 0, 0, 2);              // same value, flag still set
    tag = "R5";
    step(1, 2, 8'hFF, 0, 0, 2);
    step(1, 3, 8'hFF, 0, 0, 2);
    tag = "R7";
    step(0, 0, 0, 0, 0, 2);              // held while not ready
    step(0, 0, 0, 1, 0, 2);              // drained
    tag = "R8";
    step(1, 7, 1, 0, 0, 2);
    step(1, 6, 1, 1, 0, 2);              // write coincides with completion
    step(0, 0, 0, 0, 0, 2);
    step(0, 0, 0, 1, 0, 2);
    tag = "R9";
    step(1, 1, 8'hA2, 0, 0, 1);          // domain 2, defaults 1010
    step(1, 4, 1, 0, 0, 2);
    step(0, 0, 0, 0, 4'b1011, 2);        // other domains ignored
    step(0, 0, 0, 0, 4'b0100, 2);        // selected domain
    step(0, 0, 0, 0, 0, 5);
    tag = "R10";
    step(1, 4, 1, 0, 4'b0100, 4);        // reset wins over write
    step(1, 1, 8'h53, 0, 4'b0100, 1);    // old defaults used this cycle
    step(0, 0, 0, 0, 4'b1000, 1);
    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3], lfsr[6:4], lfsr[15:8], lfsr[17],
           (lfsr[22:20] == 0) ? (1 << lfsr[25:24]) : 0, lfsr[30:28]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule